// File: doc/BRIEF.md
# Packed SIMD Multiply-Accumulate Unit

This block is a pipelined datapath that runs packed multiply operations on register operands. Each issued operation carries two 64-bit source operands, a 64-bit accumulator operand, a 3-bit operation code, a signed/unsigned select and a mode bit that selects the 64-bit register mode. The result returns with a valid flag after one, two or three cycles, depending on the operation. One bank of lane multipliers feeds both the plain lane-wise products and the dot-product forms that add into an accumulator.

The unit accepts one operation per cycle. Results always leave in issue order. If a short operation would finish in the same cycle as, or earlier than, a longer one already in flight, the unit raises `stall` for that cycle and does not take the operation. The issuing logic holds or re-presents the operation later. In 32-bit mode only the lower 32 bits of each operand take part. In 64-bit mode the dot-product forms also compute an independent upper 32-bit result, and the wide 32x32 form becomes available.

Top module: `simdMacUnit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `outValid` is 0, `outResult` is 0 and `stall` is 0 when `inValid` is 0.
- R2: Operation code 0 forms four 8x8 products of byte lanes i=0..3 of the low 32 bits of the sources. Product i is placed in `outResult[16i+15:16i]`, and the result is valid 1 cycle after issue.
- R3: Operation code 1 forms two 16x16 products of halfword lanes j=0..1 of the low 32 bits. Product j is placed in `outResult[32j+31:32j]`, valid 1 cycle after issue.
- R4: Operation code 2 puts accumulator bits [31:0] plus the sum of the four low byte-lane products into `outResult[31:0]`, valid 2 cycles after issue.
- R5: Operation code 3 puts accumulator bits [31:0] plus the sum of the two low halfword-lane products into `outResult[31:0]`, valid 2 cycles after issue.
- R6: For codes 2 and 3 with `inMode64`=1, `outResult[63:32]` is accumulator bits [63:32] plus the same sum formed on the upper 32 bits of the sources. With `inMode64`=0 these bits are 0.
- R7: Operation code 4 with `inMode64`=1 returns the 64-bit accumulator plus the products of the two 32-bit word pairs, valid 3 cycles after issue. With `inMode64`=0 it returns 0 after 3 cycles.
- R8: `inSigned`=1 sign-extends every lane operand. `inSigned`=0 zero-extends every lane operand.
- R9: All sums wrap modulo the width of their result field (32 bits for codes 2 and 3, 64 bits for code 4), with no saturation.
- R10: Codes 5, 6 and 7 are reserved: they are accepted as 1-cycle operations and return a zero result.
- R11: `stall` is 1 exactly when `inValid` is 1 and the new operation would finish in the same cycle as, or before, an operation already in flight. A stalled operation produces no result.
- R12: Operations of equal latency issued on consecutive cycles are all accepted. Results leave in issue order, and `outResult` is 0 in every cycle in which `outValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation present this cycle |
| inOp | input | 3 | Operation code |
| inSigned | input | 1 | 1: lanes signed, 0: lanes unsigned |
| inMode64 | input | 1 | 1: 64-bit register mode |
| inSrcA | input | 64 | First source operand |
| inSrcB | input | 64 | Second source operand |
| inAcc | input | 64 | Accumulator operand |
| stall | output | 1 | Operation not accepted this cycle |
| outValid | output | 1 | Result present |
| outResult | output | 64 | Result value |

## Verification
An operation presented in cycle k is due at the output in cycle k+1 for codes 0, 1 and 5 to 7, in cycle k+2 for codes 2 and 3, and in cycle k+3 for code 4. The bench keeps a queue of due cycles and expected values, built from a behavioural integer model. In every cycle it compares the outputs either against the head of that queue or against the idle state. It predicts `stall` from the due cycles still pending, so a missed collision, an extra result or a result in the wrong cycle each show up as a mismatch in a named cycle.

// File: rtl/simdMacPkg.sv
package simdMacPkg;
  localparam int DATA_W = 64;
  localparam int HALF_W = DATA_W / 2;
  localparam int BYTE_LANES = DATA_W / 8;
  localparam int HALF_LANES = DATA_W / 16;
  localparam int WORD_LANES = DATA_W / 32;

  localparam logic [2:0] OP_BMUL = 3'd0;
  localparam logic [2:0] OP_HMUL = 3'd1;
  localparam logic [2:0] OP_BDOT = 3'd2;
  localparam logic [2:0] OP_HDOT = 3'd3;
  localparam logic [2:0] OP_WDOT = 3'd4;

  localparam logic [1:0] PK_BYTE = 2'd0;
  localparam logic [1:0] PK_HALF = 2'd1;
  localparam logic [1:0] PK_ZERO = 2'd2;

  localparam logic [1:0] SM_BYTE = 2'd0;
  localparam logic [1:0] SM_HALF = 2'd1;
  localparam logic [1:0] SM_WIDE = 2'd2;

  localparam logic [1:0] OS_NONE = 2'd0;
  localparam logic [1:0] OS_ST1 = 2'd1;
  localparam logic [1:0] OS_ST2 = 2'd2;
  localparam logic [1:0] OS_ST3 = 2'd3;

  typedef struct packed {
    logic       load1;
    logic [1:0] packSel;
    logic       load2;
    logic [1:0] sumSel;
    logic       upperEn;
    logic       load3;
    logic [1:0] outSel;
  } macStrobe_t;

  function automatic logic isDot(logic [2:0] op);
    return (op == OP_BDOT) || (op == OP_HDOT);
  endfunction

  function automatic logic isWide(logic [2:0] op);
    return op == OP_WDOT;
  endfunction

  function automatic logic isShort(logic [2:0] op);
    return !isDot(op) && !isWide(op);
  endfunction
endpackage

// File: rtl/simdMacLaneMul.sv
module simdMacLaneMul #(
  parameter int W = 8,
  parameter int P = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sgn,
  output logic [P-1:0] prod
);
  logic signed [W:0]   extA, extB;
  logic signed [P-1:0] wideA, wideB;

  always_comb begin
    extA  = {sgn & a[W-1], a};
    extB  = {sgn & b[W-1], b};
    wideA = P'(extA);
    wideB = P'(extB);
    prod  = wideA * wideB;
  end
endmodule

// File: rtl/simdMacCtrl.sv
module simdMacCtrl
  import simdMacPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [2:0] inOp,
  input  logic       inMode64,
  output logic       stall,
  output logic       outValid,
  output macStrobe_t strb
);
  logic       v1, v2, v3;
  logic [2:0] op1, op2;
  logic       m1;
  logic       occNext1, occNext2, accept;
  logic       fin1, fin2, fin3;

  always_comb begin
    occNext1 = (v1 && isDot(op1)) || (v2 && isWide(op2));
    occNext2 = v1 && isWide(op1);
    if (isShort(inOp))    stall = inValid && (occNext1 || occNext2);
    else if (isDot(inOp)) stall = inValid && occNext2;
    else                  stall = 1'b0;
    accept = inValid && !stall;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
      op1 <= OP_BMUL;
      op2 <= OP_BMUL;
      m1 <= 1'b0;
    end else begin
      v1  <= accept;
      op1 <= inOp;
      m1  <= inMode64;
      v2  <= v1 && !isShort(op1);
      op2 <= op1;
      v3  <= v2 && isWide(op2);
    end
  end

  always_comb begin
    fin1 = v1 && isShort(op1);
    fin2 = v2 && isDot(op2);
    fin3 = v3;
    strb.load1   = accept;
    strb.packSel = (op1 == OP_BMUL) ? PK_BYTE : (op1 == OP_HMUL) ? PK_HALF : PK_ZERO;
    strb.load2   = v1 && !isShort(op1);
    strb.sumSel  = isWide(op1) ? SM_WIDE : (op1 == OP_HDOT) ? SM_HALF : SM_BYTE;
    strb.upperEn = m1;
    strb.load3   = v2 && isWide(op2);
    strb.outSel  = fin1 ? OS_ST1 : fin2 ? OS_ST2 : fin3 ? OS_ST3 : OS_NONE;
    outValid     = fin1 || fin2 || fin3;
  end

  // R11: in-order retirement means at most one stage finishes per cycle
  a_r11_single_finisher: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({fin1, fin2, fin3}));

  // R7: the longest operation never has to wait
  a_r7_wide_no_stall: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && isWide(inOp)) |-> !stall);

  // R2: accepted short operation retires next cycle
  a_r2_short_latency: assert property (@(posedge clk) disable iff (!rstN)
    (accept && isShort(inOp)) |=> outValid);

  // R4: accepted dot operation retires two cycles later
  a_r4_dot_latency: assert property (@(posedge clk) disable iff (!rstN)
    (accept && isDot(inOp)) |=> ##1 outValid);

  // R7: accepted wide operation retires three cycles later
  a_r7_wide_latency: assert property (@(posedge clk) disable iff (!rstN)
    (accept && isWide(inOp)) |=> ##2 outValid);
endmodule

// File: rtl/simdMacData.sv
module simdMacData
  import simdMacPkg::*;
(
  input  logic              clk,
  input  macStrobe_t        strb,
  input  logic              inSigned,
  input  logic [DATA_W-1:0] inSrcA,
  input  logic [DATA_W-1:0] inSrcB,
  input  logic [DATA_W-1:0] inAcc,
  output logic [DATA_W-1:0] outResult
);
  logic [HALF_W-1:0] prodB [BYTE_LANES];
  logic [HALF_W-1:0] prodH [HALF_LANES];
  logic [DATA_W-1:0] prodW [WORD_LANES];

  for (genvar i = 0; i < BYTE_LANES; i++) begin : g_byte
    simdMacLaneMul #(.W(8), .P(HALF_W)) u_mul (
      .a(inSrcA[8*i +: 8]), .b(inSrcB[8*i +: 8]), .sgn(inSigned), .prod(prodB[i]));
  end
  for (genvar i = 0; i < HALF_LANES; i++) begin : g_half
    simdMacLaneMul #(.W(16), .P(HALF_W)) u_mul (
      .a(inSrcA[16*i +: 16]), .b(inSrcB[16*i +: 16]), .sgn(inSigned), .prod(prodH[i]));
  end
  for (genvar i = 0; i < WORD_LANES; i++) begin : g_word
    simdMacLaneMul #(.W(32), .P(DATA_W)) u_mul (
      .a(inSrcA[32*i +: 32]), .b(inSrcB[32*i +: 32]), .sgn(inSigned), .prod(prodW[i]));
  end

  logic [HALF_W-1:0] s1B [BYTE_LANES];
  logic [HALF_W-1:0] s1H [HALF_LANES];
  logic [DATA_W-1:0] s1W [WORD_LANES];
  logic [DATA_W-1:0] s1Acc, s2Res, s2Acc, s3Res, packed1;
  logic [HALF_W-1:0] byteLo, byteHi, halfLo, halfHi;
  logic [DATA_W-1:0] wideSum;

  always_ff @(posedge clk) begin
    if (strb.load1) begin
      for (int i = 0; i < BYTE_LANES; i++) s1B[i] <= prodB[i];
      for (int i = 0; i < HALF_LANES; i++) s1H[i] <= prodH[i];
      for (int i = 0; i < WORD_LANES; i++) s1W[i] <= prodW[i];
      s1Acc <= inAcc;
    end
  end

  always_comb begin
    packed1 = '0;
    if (strb.packSel == PK_BYTE)
      for (int i = 0; i < 4; i++) packed1[16*i +: 16] = s1B[i][15:0];
    else if (strb.packSel == PK_HALF)
      packed1 = {s1H[1], s1H[0]};
    byteLo = s1Acc[HALF_W-1:0];
    byteHi = s1Acc[DATA_W-1:HALF_W];
    for (int i = 0; i < BYTE_LANES / 2; i++) begin
      byteLo = byteLo + s1B[i];
      byteHi = byteHi + s1B[i + BYTE_LANES / 2];
    end
    halfLo = s1Acc[HALF_W-1:0];
    halfHi = s1Acc[DATA_W-1:HALF_W];
    for (int i = 0; i < HALF_LANES / 2; i++) begin
      halfLo = halfLo + s1H[i];
      halfHi = halfHi + s1H[i + HALF_LANES / 2];
    end
    wideSum = '0;
    for (int i = 0; i < WORD_LANES; i++) wideSum = wideSum + s1W[i];
  end

  always_ff @(posedge clk) begin
    if (strb.load2) begin
      case (strb.sumSel)
        SM_BYTE: begin
          s2Res <= {strb.upperEn ? byteHi : '0, byteLo};
          s2Acc <= '0;
        end
        SM_HALF: begin
          s2Res <= {strb.upperEn ? halfHi : '0, halfLo};
          s2Acc <= '0;
        end
        default: begin
          s2Res <= strb.upperEn ? wideSum : '0;
          s2Acc <= strb.upperEn ? s1Acc : '0;
        end
      endcase
    end
    if (strb.load3) s3Res <= s2Res + s2Acc;
  end

  always_comb begin
    case (strb.outSel)
      OS_ST1:  outResult = packed1;
      OS_ST2:  outResult = s2Res;
      OS_ST3:  outResult = s3Res;
      default: outResult = '0;
    endcase
  end
endmodule

// File: rtl/simdMacUnit.sv
module simdMacUnit
  import simdMacPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [2:0]  inOp,
  input  logic        inSigned,
  input  logic        inMode64,
  input  logic [63:0] inSrcA,
  input  logic [63:0] inSrcB,
  input  logic [63:0] inAcc,
  output logic        stall,
  output logic        outValid,
  output logic [63:0] outResult
);
  macStrobe_t strb;

  simdMacCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inOp(inOp), .inMode64(inMode64),
    .stall(stall), .outValid(outValid), .strb(strb));

  simdMacData u_data (
    .clk(clk), .strb(strb), .inSigned(inSigned), .inSrcA(inSrcA), .inSrcB(inSrcB),
    .inAcc(inAcc), .outResult(outResult));
endmodule

// File: tb/simdMacUnit_tb_top.sv
`timescale 1ns/1ps
module simdMacUnit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [2:0]  inOp = 3'd0;
  logic        inSigned = 1'b0;
  logic        inMode64 = 1'b0;
  logic [63:0] inSrcA = '0, inSrcB = '0, inAcc = '0;
  logic        stall, outValid;
  logic [63:0] outResult;

  int nChecks = 0;
  int nErrors = 0;
  int cyc = 0;
  int          dueQ[$];
  logic [63:0] valQ[$];
  string       tagQ[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  simdMacUnit dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inOp(inOp), .inSigned(inSigned),
    .inMode64(inMode64), .inSrcA(inSrcA), .inSrcB(inSrcB), .inAcc(inAcc),
    .stall(stall), .outValid(outValid), .outResult(outResult));

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s cycle %0d actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  function automatic longint ext(logic [63:0] v, int pos, int w, bit sgn);
    longint x;
    x = longint'((v >> pos) & ((64'd1 << w) - 64'd1));
    if (sgn && x[w-1]) x = x - (longint'(1) << w);
    return x;
  endfunction

  function automatic int latOf(logic [2:0] op);
    if (op == 3'd2 || op == 3'd3) return 2;
    if (op == 3'd4) return 3;
    return 1;
  endfunction

  function automatic string tagOf(logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R7";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [63:0] refCalc(logic [2:0] op, bit sgn, bit m64,
                                          logic [63:0] a, logic [63:0] b, logic [63:0] acc);
    logic [63:0] r;
    longint p, lo, hi;
    r = '0;
    case (op)
      3'd0: for (int i = 0; i < 4; i++) begin
        p = ext(a, 8*i, 8, sgn) * ext(b, 8*i, 8, sgn);
        r[16*i +: 16] = p[15:0];
      end
      3'd1: for (int i = 0; i < 2; i++) begin
        p = ext(a, 16*i, 16, sgn) * ext(b, 16*i, 16, sgn);
        r[32*i +: 32] = p[31:0];
      end
      3'd2, 3'd3: begin
        int w;
        int n;
        w = (op == 3'd2) ? 8 : 16;
        n = 32 / w;
        lo = longint'(acc[31:0]);
        hi = longint'(acc[63:32]);
        for (int i = 0; i < n; i++) begin
          lo = lo + ext(a, w*i, w, sgn) * ext(b, w*i, w, sgn);
          hi = hi + ext(a, 32 + w*i, w, sgn) * ext(b, 32 + w*i, w, sgn);
        end
        r = {m64 ? hi[31:0] : 32'd0, lo[31:0]};
      end
      3'd4: if (m64) begin
        p = longint'(acc) + ext(a, 0, 32, sgn) * ext(b, 0, 32, sgn)
                          + ext(a, 32, 32, sgn) * ext(b, 32, 32, sgn);
        r = p;
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  // One cycle: check outputs, present a new operation, check stall, record the expectation
  task automatic step(bit v, logic [2:0] op, bit sgn, bit m64,
                      logic [63:0] a, logic [63:0] b, logic [63:0] acc, string tag);
    bit expStall;
    int lat;
    @(negedge clk);
    if (dueQ.size() > 0 && dueQ[0] == cyc) begin
      chk(outValid === 1'b1, tagQ[0], {63'd0, outValid}, 64'd1);
      chk(outResult === valQ[0], tagQ[0], outResult, valQ[0]);
      void'(dueQ.pop_front());
      void'(valQ.pop_front());
      void'(tagQ.pop_front());
    end else begin
      // R12: idle cycles show no result
      chk(outValid === 1'b0 && outResult === 64'd0, "R12", outResult, 64'd0);
    end
    inValid = v; inOp = op; inSigned = sgn; inMode64 = m64;
    inSrcA = a; inSrcB = b; inAcc = acc;
    #1;
    lat = latOf(op);
    expStall = 1'b0;
    if (v) foreach (dueQ[k]) if (dueQ[k] >= cyc + lat) expStall = 1'b1;
    chk(stall === expStall, "R11", {63'd0, stall}, {63'd0, expStall});
    if (v && !expStall) begin
      dueQ.push_back(cyc + lat);
      valQ.push_back(refCalc(op, sgn, m64, a, b, acc));
      tagQ.push_back(tag);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 3'd0, 1'b0, 1'b0, '0, '0, '0, "R12");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog R11 actual=%0d expected=done", cyc);
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    logic [63:0] ra, rb, rc;
    logic [2:0]  rop;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(outValid === 1'b0 && outResult === 64'd0, "R1", outResult, 64'd0);
    rstN = 1'b1;
    #1;
    chk(stall === 1'b0, "R1", {63'd0, stall}, 64'd0);
    idle(1);

    // R2 / R8: byte products, unsigned then signed
    step(1, 3'd0, 0, 0, 64'h1234_5678_FF10_0302, 64'h9ABC_DEF0_FF05_0704, 0, "R2");
    step(1, 3'd0, 1, 0, 64'h1234_5678_FF10_0302, 64'h9ABC_DEF0_FF05_0704, 0, "R8");
    idle(2);
    // R3 / R8: halfword products
    step(1, 3'd1, 0, 0, 64'h0000_0000_FFFF_1234, 64'h0000_0000_8000_0010, 0, "R3");
    step(1, 3'd1, 1, 0, 64'h0000_0000_FFFF_1234, 64'h0000_0000_8000_0010, 0, "R8");
    idle(2);
    // R4, R5: dot forms in 32-bit mode (upper half must read zero, R6)
    step(1, 3'd2, 0, 0, 64'h0102_0304_0A0B_0C0D, 64'h0506_0708_0102_0304, 64'h5555_5555_0000_0064, "R4");
    step(1, 3'd3, 1, 0, 64'h7FFF_0001_FFFE_0003, 64'h0002_0002_0005_0007, 64'h0000_0001_0000_0010, "R5");
    idle(3);
    // R6: upper half runs as an independent result in 64-bit mode
    step(1, 3'd2, 1, 1, 64'hFF80_0102_0304_0506, 64'h0280_FF7F_0102_0304, 64'h0000_0100_0000_0200, "R6");
    step(1, 3'd3, 0, 1, 64'hFFFF_0002_1000_2000, 64'hFFFF_0003_0010_0020, 64'h1000_0000_2000_0000, "R6");
    idle(3);
    // R7: wide form, both signednesses, and zero in 32-bit mode
    step(1, 3'd4, 1, 1, 64'hFFFF_FFFE_0000_0003, 64'h0000_0005_FFFF_FFF9, 64'h0000_0000_0000_0064, "R7");
    step(1, 3'd4, 0, 1, 64'hFFFF_FFFF_8000_0000, 64'hFFFF_FFFF_0000_0002, 64'h1, "R7");
    step(1, 3'd4, 1, 0, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 64'h77, "R7");
    idle(4);
    // R9: wrap of the accumulator fields
    step(1, 3'd2, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R9");
    step(1, 3'd4, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFF0, "R9");
    idle(4);
    // R10: reserved codes
    step(1, 3'd5, 1, 1, 64'hAAAA_BBBB_CCCC_DDDD, 64'h1111_2222_3333_4444, 64'h5, "R10");
    step(1, 3'd6, 0, 0, 64'hAAAA_BBBB_CCCC_DDDD, 64'h1111_2222_3333_4444, 64'h5, "R10");
    step(1, 3'd7, 0, 1, 64'hAAAA_BBBB_CCCC_DDDD, 64'h1111_2222_3333_4444, 64'h5, "R10");
    idle(2);
    // R11: collisions stall, later issue succeeds
    step(1, 3'd2, 0, 0, 64'h0403_0201, 64'h0101_0101, 64'h10, "R11");
    step(1, 3'd0, 0, 0, 64'h0202_0202, 64'h0303_0303, 0, "R11");
    step(1, 3'd0, 0, 0, 64'h0202_0202, 64'h0303_0303, 0, "R11");
    idle(2);
    step(1, 3'd4, 0, 1, 64'h2_0000_0003, 64'h5_0000_0007, 64'h9, "R11");
    step(1, 3'd3, 0, 1, 64'h0001_0002, 64'h0003_0004, 0, "R11");
    step(1, 3'd1, 0, 0, 64'h0001_0002, 64'h0003_0004, 0, "R11");
    step(1, 3'd1, 0, 0, 64'h0001_0002, 64'h0003_0004, 0, "R11");
    idle(3);
    step(1, 3'd4, 0, 1, 64'h1_0000_0001, 64'h1_0000_0001, 0, "R11");
    idle(2);
    step(1, 3'd0, 0, 0, 64'h0101_0101, 64'h0202_0202, 0, "R11");
    idle(3);
    // R12: equal-latency ops back to back
    for (int i = 0; i < 4; i++)
      step(1, 3'd0, 1, 0, 64'(i * 32'h0102_0304 + 7), 64'(32'hF0E0_D0C0 - i), 0, "R12");
    for (int i = 0; i < 4; i++)
      step(1, 3'd2, 1, 1, {2{32'(i * 32'h1357_9BDF)}}, {2{32'(32'h8642_0ACE + i)}}, 64'(i), "R12");
    for (int i = 0; i < 3; i++)
      step(1, 3'd4, 1, 1, {32'(i + 1), 32'hFFFF_FFF0}, {32'd3, 32'(i + 2)}, 64'(i * 100), "R12");
    idle(4);

    // Mixed random traffic against the model
    for (int i = 0; i < 600; i++) begin
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      rc = {$urandom, $urandom};
      rop = 3'($urandom_range(0, 7));
      step(($urandom_range(0, 9) < 8), rop, 1'($urandom), 1'($urandom), ra, rb, rc, tagOf(rop));
    end
    idle(5);
    chk(dueQ.size() == 0, "R12", 64'(dueQ.size()), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule